// File: doc/BRIEF.md
# MMU Access Permission Checker with Fault Registers

This block sits after a page-table walker. For each completed translation it takes the kind of access (data read, data write, instruction fetch, user or supervisor), the 3-bit access-rights field and modified flag of the final page-table entry, and any fault code the walker produced. It then decides whether the access may proceed. One cycle later it returns an error code, a read/write/execute permission set for the TLB fill, and at most one trap request (instruction access or data access).

Every fault is logged in a fault status register and a fault address register. These can be read through a small register port. Reading the status register clears it, so software that drains it between faults never sees the overflow mark. A no-fault control input and a traps-enabled input let a fault pass through with full permissions instead of trapping.

Top module: `mmu_access_guard`

## Requirements
- R1: For a logged fault, status bits [7:5] hold the access index {write, ifetch, supervisor}, with write as bit 7 and supervisor as bit 5.
- R2: With walk_code zero, the error code depends on the access kind and the access field (af):
  - A user access with af 6 or 7 gives 12 (privilege).
  - Otherwise, a plain data read is refused (8) only for af 4.
  - A fetch needs af in {2,3,4,6,7}.
  - A write needs af in {1,3}, or af in {5,7} for a supervisor.
  - An access that is both a write and a fetch must pass both tests.
  - Any refusal gives 8; an allowed access gives 0.
- R3: When nofault_mode is 1 and the access is in user mode, a nonzero R2 error is replaced by 0 and the access is treated as allowed.
- R4: An allowed access gets perm bits (bit0 read, bit1 write, bit2 execute) by af:
  - af 0 to 4 give R, RW, RX, RWX and X in both modes.
  - For af 5, 6 and 7 a user gets R, X and X.
  - For af 5, 6 and 7 a supervisor gets RW, RX and RWX.
- R5: For an allowed access whose pte_dirty is 0, perm bit1 (write) is 0.
- R6: A fault with a nonzero status register first reduces the register to 1 (overflow, bit0). The access index, the error code and bit1 (address valid) are then ORed in. A fault with a zero status register gives only those three fields.
- R7: On a fault, the address register loads acc_vaddr with its low 12 bits cleared.
- R8: A faulting access with nofault_mode 1 or traps_on 0 returns perm 3'b111, raises no trap, and still reports and logs the error.
- R9: Otherwise a faulting fetch raises trap_iacc, a faulting data access raises trap_dacc, and the perm set is 0. The two traps are never high together.
- R10: A read with reg_sel 0 returns the status register one cycle later and clears it. When a fault arrives in the same cycle, the new status is built from the cleared value, so it has no overflow. A read with reg_sel 1 returns the address register and does not clear it.
- R11: After reset the response outputs and both registers are zero. Each response appears in the cycle after the acc_valid cycle.
- R12: A nonzero walk_code is the error code as given. It bypasses R2 and R3, is logged per R6, and follows R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A translated access is presented this cycle |
| acc_write | input | 1 | Access is a write |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_vaddr | input | DATA_W | Virtual address of the access |
| pte_acc | input | 3 | Access-rights field of the final entry |
| pte_dirty | input | 1 | Modified flag of the final entry |
| walk_code | input | ERR_W | Walker fault code, zero if the walk succeeded |
| nofault_mode | input | 1 | No-fault control |
| traps_on | input | 1 | Traps enabled |
| resp_valid | output | 1 | Response valid |
| resp_err | output | ERR_W | Error code, zero if allowed |
| resp_perm | output | 3 | Fill permissions {X, W, R} |
| trap_iacc | output | 1 | Instruction-access trap request |
| trap_dacc | output | 1 | Data-access trap request |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects address |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |

## Verification
The assertions assume that walk_code, when nonzero, never carries bits [7:5] or bit1. Under that assumption the logged fields stay separable and an error code never looks like the overflow or valid marks. They also assume that acc_valid and reg_rd are never X after reset. The stimulus keeps to this: it uses only walker codes that combine level bits [9:8] with type bits [4:2], and it drives every control input to a known value in every cycle.

// File: rtl/mmu_guard_pkg.sv
// Package: shared constants and decision functions for the access guard.
// Assumes permission vectors are ordered {X, W, R}.
package mmu_guard_pkg;
    localparam int ERR_W      = 10;
    localparam int PERM_W     = 3;
    localparam logic [2:0] P_R = 3'b001;
    localparam logic [2:0] P_W = 3'b010;
    localparam logic [2:0] P_X = 3'b100;
    localparam logic [3:0] CODE_PROT = 4'd8;
    localparam logic [3:0] CODE_PRIV = 4'd12;

    typedef logic [2:0] acc_idx_t;

    // Access index: write at bit 2, fetch at bit 1, supervisor at bit 0.
    function automatic acc_idx_t make_index(input logic wr, input logic fe, input logic sv);
        return {wr, fe, sv};
    endfunction

    // Rights check derived from per-kind allowed sets.
    function automatic logic [3:0] rights_code(input acc_idx_t ai, input logic [2:0] af);
        logic ok;
        logic x_ok;
        logic w_ok;
        if (!ai[0] && af[2:1] == 2'b11) begin
            return CODE_PRIV;
        end
        x_ok = (af == 3'd2) || (af == 3'd3) || (af == 3'd4) || (af == 3'd6) || (af == 3'd7);
        w_ok = (af == 3'd1) || (af == 3'd3) || (ai[0] && (af == 3'd5 || af == 3'd7));
        ok = 1'b1;
        if (ai[1]) ok = ok & x_ok;
        if (ai[2]) ok = ok & w_ok;
        if (!ai[1] && !ai[2]) ok = (af != 3'd4);
        return ok ? 4'd0 : CODE_PROT;
    endfunction

    // Fill permission set for an allowed access.
    function automatic logic [2:0] fill_perm(input logic sv, input logic [2:0] af);
        case (af)
            3'd0:    return P_R;
            3'd1:    return P_R | P_W;
            3'd2:    return P_R | P_X;
            3'd3:    return P_R | P_W | P_X;
            3'd4:    return P_X;
            3'd5:    return sv ? (P_R | P_W) : P_R;
            3'd6:    return sv ? (P_R | P_X) : P_X;
            default: return sv ? (P_R | P_W | P_X) : P_X;
        endcase
    endfunction
endpackage

// File: rtl/mmu_access_judge.sv
// Module: combinational judgement of one access.
// Walker codes take precedence; no-fault only masks rights errors of user accesses.
module mmu_access_judge
    import mmu_guard_pkg::*;
#(
    parameter int CODE_W = ERR_W
) (
    input  logic              is_write,
    input  logic              is_fetch,
    input  logic              is_super,
    input  logic [2:0]        af,
    input  logic              dirty,
    input  logic              nofault,
    input  logic [CODE_W-1:0] walk_code,
    output acc_idx_t          ai,
    output logic [CODE_W-1:0] code,
    output logic              faulted,
    output logic [2:0]        perm_ok
);
    logic [3:0] rcode;

    // Derive index, rights error and the unmasked-by-fault permission set.
    always_comb begin
        ai    = make_index(is_write, is_fetch, is_super);
        rcode = rights_code(ai, af);
        if (walk_code != '0) begin
            code = walk_code;
        end else if (nofault && !is_super) begin
            code = '0;
        end else begin
            code = {{(CODE_W-4){1'b0}}, rcode};
        end
        faulted = (code != '0);
        perm_ok = fill_perm(is_super, af);
        if (!dirty) perm_ok = perm_ok & ~P_W;
    end
endmodule

// File: rtl/mmu_fault_regs.sv
// Module: fault status and fault address registers.
// A clear request in the same cycle as a fault is applied before the fault update.
module mmu_fault_regs
    import mmu_guard_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CODE_W     = ERR_W,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  acc_idx_t          ai,
    input  logic [CODE_W-1:0] code,
    input  logic [DATA_W-1:0] vaddr,
    input  logic              clr,
    output logic [DATA_W-1:0] fsr_q,
    output logic [DATA_W-1:0] far_q
);
    localparam logic [DATA_W-1:0] PAGE_MASK = {DATA_W{1'b1}} << PAGE_SHIFT;
    localparam int                IDX_LSB   = 5;

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] fsr_n;

    // Compose the next status value from the (possibly cleared) current one.
    always_comb begin
        base  = clr ? '0 : fsr_q;
        fsr_n = base;
        if (log_en) begin
            fsr_n = (base != '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : '0;
            fsr_n = fsr_n | ({{(DATA_W-3){1'b0}}, ai} << IDX_LSB)
                          | {{(DATA_W-CODE_W){1'b0}}, code}
                          | {{(DATA_W-2){1'b0}}, 2'b10};
        end
    end

    // Register the status and the page-aligned fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_n;
            if (log_en) far_q <= vaddr & PAGE_MASK;
        end
    end
endmodule

// File: rtl/mmu_reg_port.sv
// Module: register read port; reading status requests a clear.
module mmu_reg_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              sel,
    input  logic [DATA_W-1:0] fsr,
    input  logic [DATA_W-1:0] far,
    output logic              clr,
    output logic [DATA_W-1:0] rdata
);
    // Status read triggers read-clear.
    assign clr = rd && !sel;

    // Capture the selected register value.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) rdata <= sel ? far : fsr;
    end
endmodule

// File: rtl/mmu_access_guard.sv
// Module: top of the permission checker; responses are registered one cycle.
// Assumes acc_valid qualifies all access inputs.
module mmu_access_guard
    import mmu_guard_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CODE_W     = ERR_W,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ifetch,
    input  logic              acc_super,
    input  logic [DATA_W-1:0] acc_vaddr,
    input  logic [2:0]        pte_acc,
    input  logic              pte_dirty,
    input  logic [CODE_W-1:0] walk_code,
    input  logic              nofault_mode,
    input  logic              traps_on,
    output logic              resp_valid,
    output logic [CODE_W-1:0] resp_err,
    output logic [2:0]        resp_perm,
    output logic              trap_iacc,
    output logic              trap_dacc,
    input  logic              reg_rd,
    input  logic              reg_sel,
    output logic [DATA_W-1:0] reg_rdata
);
    acc_idx_t          ai;
    logic [CODE_W-1:0] code;
    logic              faulted;
    logic [2:0]        perm_ok;
    logic              log_fault;
    logic              override;
    logic              clr_status;
    logic [DATA_W-1:0] fsr_q;
    logic [DATA_W-1:0] far_q;

    mmu_access_judge #(.CODE_W(CODE_W)) judge_i (
        .is_write (acc_write),
        .is_fetch (acc_ifetch),
        .is_super (acc_super),
        .af       (pte_acc),
        .dirty    (pte_dirty),
        .nofault  (nofault_mode),
        .walk_code(walk_code),
        .ai       (ai),
        .code     (code),
        .faulted  (faulted),
        .perm_ok  (perm_ok)
    );

    assign log_fault = acc_valid && faulted;
    assign override  = nofault_mode || !traps_on;

    mmu_fault_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .PAGE_SHIFT(PAGE_SHIFT)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .log_en(log_fault),
        .ai    (ai),
        .code  (code),
        .vaddr (acc_vaddr),
        .clr   (clr_status),
        .fsr_q (fsr_q),
        .far_q (far_q)
    );

    mmu_reg_port #(.DATA_W(DATA_W)) port_i (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (reg_rd),
        .sel  (reg_sel),
        .fsr  (fsr_q),
        .far  (far_q),
        .clr  (clr_status),
        .rdata(reg_rdata)
    );

    // Register the decision, permission set and trap request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= '0;
            resp_perm  <= '0;
            trap_iacc  <= 1'b0;
            trap_dacc  <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            trap_iacc  <= 1'b0;
            trap_dacc  <= 1'b0;
            if (acc_valid) begin
                resp_err <= code;
                if (!faulted) begin
                    resp_perm <= perm_ok;
                end else if (override) begin
                    resp_perm <= P_R | P_W | P_X;
                end else begin
                    resp_perm <= '0;
                    trap_iacc <= acc_ifetch;
                    trap_dacc <= !acc_ifetch;
                end
            end
        end
    end
endmodule

// File: rtl/mmu_access_guard_chk.sv
// Module: assertion checker bound to the top; observes ports and register state.
module mmu_access_guard_chk #(
    parameter int DATA_W     = 32,
    parameter int CODE_W     = 10,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [DATA_W-1:0] acc_vaddr,
    input logic [CODE_W-1:0] walk_code,
    input logic              nofault_mode,
    input logic              traps_on,
    input logic              resp_valid,
    input logic [CODE_W-1:0] resp_err,
    input logic [2:0]        resp_perm,
    input logic              trap_iacc,
    input logic              trap_dacc,
    input logic              reg_rd,
    input logic              reg_sel,
    input logic              pte_dirty,
    input logic              log_fault,
    input logic [DATA_W-1:0] fsr_q,
    input logic [DATA_W-1:0] far_q
);
    // R9: never both traps.
    a_r9_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_iacc, trap_dacc}));

    // R8: override inputs suppress traps.
    a_r8_no_trap_override: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (nofault_mode || !traps_on) |=> !trap_iacc && !trap_dacc);

    // R6: a logged fault sets the address-valid bit.
    a_r6_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        log_fault |=> fsr_q[1]);

    // R6: a fault over unread status marks overflow.
    a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        log_fault && fsr_q != '0 && !(reg_rd && !reg_sel) |=> fsr_q[0]);

    // R10: a status read with no fault leaves the register clear.
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !reg_sel && !log_fault |=> fsr_q == '0);

    // R7: address register takes the page number of the faulting access.
    a_r7_far_page: assert property (@(posedge clk) disable iff (!rst_n)
        log_fault |=> far_q[DATA_W-1:PAGE_SHIFT] == $past(acc_vaddr[DATA_W-1:PAGE_SHIFT]));

    // R5: allowed access on an unmodified page carries no write permission.
    a_r5_no_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !pte_dirty |=> resp_err != '0 || !resp_perm[1]);

    // R2: rights-only errors are 0, 8 or 12.
    a_r2_codes: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && walk_code == '0 |=> resp_valid &&
        (resp_err == 'd0 || resp_err == 'd8 || resp_err == 'd12));
endmodule

bind mmu_access_guard mmu_access_guard_chk #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .PAGE_SHIFT(PAGE_SHIFT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_vaddr   (acc_vaddr),
    .walk_code   (walk_code),
    .nofault_mode(nofault_mode),
    .traps_on    (traps_on),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err),
    .resp_perm   (resp_perm),
    .trap_iacc   (trap_iacc),
    .trap_dacc   (trap_dacc),
    .reg_rd      (reg_rd),
    .reg_sel     (reg_sel),
    .pte_dirty   (pte_dirty),
    .log_fault   (log_fault),
    .fsr_q       (fsr_q),
    .far_q       (far_q)
);

// File: tb/mmu_access_guard_tb_top.sv
// Scoreboard bench: the driver queues expected responses and reads; monitors compare.
module mmu_access_guard_tb_top;
    localparam int DW = 32;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 0, acc_write = 0, acc_ifetch = 0, acc_super = 0;
    logic [DW-1:0] acc_vaddr = '0;
    logic [2:0]    pte_acc = '0;
    logic          pte_dirty = 0;
    logic [CW-1:0] walk_code = '0;
    logic          nofault_mode = 0, traps_on = 1;
    logic          resp_valid;
    logic [CW-1:0] resp_err;
    logic [2:0]    resp_perm;
    logic          trap_iacc, trap_dacc;
    logic          reg_rd = 0, reg_sel = 0;
    logic [DW-1:0] reg_rdata;

    always #10 clk = ~clk;

    mmu_access_guard dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ifetch(acc_ifetch), .acc_super(acc_super), .acc_vaddr(acc_vaddr),
        .pte_acc(pte_acc), .pte_dirty(pte_dirty), .walk_code(walk_code),
        .nofault_mode(nofault_mode), .traps_on(traps_on), .resp_valid(resp_valid),
        .resp_err(resp_err), .resp_perm(resp_perm), .trap_iacc(trap_iacc),
        .trap_dacc(trap_dacc), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
    );

    typedef struct {
        logic [CW-1:0] err;
        logic [2:0]    perm;
        logic          ti;
        logic          td;
        string         tag;
    } resp_t;

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
    } rd_t;

    resp_t resp_q[$];
    rd_t   rd_q[$];
    int    checks = 0;
    int    errors = 0;
    logic  rd_seen = 0;
    logic [DW-1:0] m_fsr = '0;
    logic [DW-1:0] m_far = '0;

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected rights code: one nibble per access field, field 0 in the top nibble.
    function automatic logic [3:0] exp_code(input logic [2:0] ai, input logic [2:0] af);
        logic [31:0] row;
        case (ai)
            3'd0: row = 32'h0000_80cc;
            3'd1: row = 32'h0000_8000;
            3'd2: row = 32'h8800_08cc;
            3'd3: row = 32'h8800_0800;
            3'd4: row = 32'h8080_88cc;
            3'd5: row = 32'h8080_8080;
            3'd6: row = 32'h8880_88cc;
            default: row = 32'h8880_8880;
        endcase
        return row[31 - 4*af -: 4];
    endfunction

    function automatic logic [2:0] exp_perm(input logic sv, input logic [2:0] af);
        logic [31:0] row;
        row = sv ? 32'h1357_4357 : 32'h1357_4144;
        return row[30 - 4*af -: 3];
    endfunction

    // Drive one cycle: optional access and optional register read; update the model.
    task automatic step(input logic av, input logic w, input logic x, input logic s,
                        input logic [2:0] af, input logic d, input logic nf, input logic ten,
                        input logic [CW-1:0] wc, input logic [DW-1:0] va,
                        input logic rd, input logic sel, input string tag);
        resp_t r;
        logic [CW-1:0] e;
        logic [2:0] ai;
        @(negedge clk);
        acc_valid = av; acc_write = w; acc_ifetch = x; acc_super = s; pte_acc = af;
        pte_dirty = d; nofault_mode = nf; traps_on = ten; walk_code = wc; acc_vaddr = va;
        reg_rd = rd; reg_sel = sel;
        if (rd) begin
            rd_q.push_back('{sel ? m_far : m_fsr, tag});
            if (!sel) m_fsr = '0;
        end
        if (av) begin
            ai = {w, x, s};
            if (wc != '0) e = wc;
            else if (nf && !s) e = '0;
            else e = {6'd0, exp_code(ai, af)};
            r.err = e; r.tag = tag; r.ti = 0; r.td = 0;
            if (e == '0) begin
                r.perm = exp_perm(s, af);
                if (!d) r.perm[1] = 1'b0;
            end else begin
                m_fsr = (m_fsr != '0) ? 32'd1 : 32'd0;
                m_fsr = m_fsr | ({29'd0, ai} << 5) | {22'd0, e} | 32'd2;
                m_far = va & 32'hffff_f000;
                if (nf || !ten) r.perm = 3'b111;
                else begin
                    r.perm = 3'b000; r.ti = x; r.td = !x;
                end
            end
            resp_q.push_back(r);
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 0, 0, "");
    endtask

    always @(posedge clk) rd_seen <= reg_rd;

    // Monitor: compare responses and read data against queued expectations.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (resp_q.size() == 0) check(0, "R11 unexpected response", 1, 0);
            else begin
                resp_t e;
                e = resp_q.pop_front();
                check(resp_err == e.err, {e.tag, " err"}, DW'(resp_err), DW'(e.err));
                check(resp_perm == e.perm, {e.tag, " perm"}, DW'(resp_perm), DW'(e.perm));
                check({trap_iacc, trap_dacc} == {e.ti, e.td}, {e.tag, " trap R9"},
                      DW'({trap_iacc, trap_dacc}), DW'({e.ti, e.td}));
            end
        end
        if (rst_n && rd_seen && rd_q.size() != 0) begin
            rd_t q;
            q = rd_q.pop_front();
            check(reg_rdata == q.val, {q.tag, " read"}, reg_rdata, q.val);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state.
        check(resp_valid == 0 && trap_iacc == 0 && trap_dacc == 0, "R11 reset outputs",
              DW'({resp_valid, trap_iacc, trap_dacc}), 0);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R11 status after reset");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 1, "R11 address after reset");
        idle();
        // R2 R4 R1 R6 R7 R9: full sweep with modified pages; drain status each time.
        for (int a = 0; a < 8; a++) begin
            for (int f = 0; f < 8; f++) begin
                step(1, a[2], a[1], a[0], f[2:0], 1, 0, 1, '0,
                     32'h1357_9abc + 32'h0101_1111 * (a*8+f), 0, 0, "R2 R4 sweep");
                step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R1 R6 status after sweep");
                step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 1, "R7 address after sweep");
            end
        end
        // R5: unmodified pages lose write permission.
        for (int f = 0; f < 8; f++) step(1, 0, 0, 1, f[2:0], 0, 0, 1, '0, 32'h4000_0000, 0, 0, "R5 clean page");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R5 status");
        // R3: no-fault user masks rights errors, supervisor does not.
        step(1, 0, 0, 0, 3'd4, 1, 1, 1, '0, 32'h5000_1234, 0, 0, "R3 user read af4");
        step(1, 1, 0, 0, 3'd6, 1, 1, 1, '0, 32'h5000_2234, 0, 0, "R3 user write af6");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R3 status stays clear");
        // R8: supervisor fault under no-fault and under traps off.
        step(1, 0, 0, 1, 3'd4, 1, 1, 1, '0, 32'h6000_5678, 0, 0, "R8 nofault super");
        step(1, 0, 1, 1, 3'd0, 1, 0, 0, '0, 32'h6100_0fff, 0, 0, "R8 traps off");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R6 overflow status");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 1, "R7 address");
        // R12: walker codes bypass the rights table and no-fault masking.
        step(1, 0, 0, 0, 3'd3, 1, 1, 1, 10'h104, 32'h7000_0000, 0, 0, "R12 walk nofault");
        step(1, 0, 1, 0, 3'd3, 1, 0, 1, 10'h310, 32'h7100_0abc, 0, 0, "R12 walk fetch trap");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R12 status");
        // R10: read and fault together; new status without overflow.
        step(1, 1, 0, 0, 3'd0, 1, 0, 1, '0, 32'h8000_1000, 0, 0, "R10 first fault");
        step(1, 0, 0, 0, 3'd4, 1, 0, 1, '0, 32'h8100_2000, 1, 0, "R10 read with fault");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 1, "R10 address no clear");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 1, "R10 address read twice");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R10 status no overflow");
        step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, 1, 0, "R10 status cleared");
        idle();
        idle();
        idle();
        if (resp_q.size() != 0 || rd_q.size() != 0)
            check(0, "R11 missing responses", DW'(resp_q.size() + rd_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule